// File: doc/BRIEF.md
# Encoder Link Master with Round-Trip Delay Compensation

This block is the master of a clocked, half-duplex serial link to an absolute position encoder. When the host asks for a transfer, the block runs a burst on a clock line that otherwise rests high. It gives two lead-in pulses and then six command bits, during which it enables the external transceiver's driver. It then releases the data line and clocks out the encoder's reply. The reply is a start bit, two error bits, the position value and a 5-bit check code. The block returns the position, the error bits, a check-code mismatch flag, a timeout flag and the measured line delay in one response pulse.

A long cable delays the returning data by up to several clock periods, so the reply cannot be sampled on the generated edges. The block counts system clocks from the first reply-phase falling edge to the arrival of the start bit. It then samples every later bit at that same offset from its own falling edge, plus half a clock period, which places each sample in the middle of the bit. The clock half-period, the start-bit timeout and the idle recovery time are set per request.

Top module: `enc_link_master`

## Requirements
- R1: `enc_clk` is high whenever no transfer is running, including the whole recovery interval.
- R2: A transfer starts with two falling edges of `enc_clk`. Falling edges 3 to 8 each place one command bit on `enc_dout`, MSB first. The command is the 3-bit `req_code` followed by its bitwise inverse, so code 3'b101 gives 6'b101010.
- R3: `enc_dir` (1 = master drives the data line) is high only from the 3rd falling edge until the 9th falling edge, so it covers six rising edges.
- R4: The reply is, in bit order: a start bit (1), two error bits (the first received goes to `rsp_err[1]`), `POS_W` position bits MSB first, and 5 check bits MSB first. `rsp_pos` and `rsp_err` return the received fields.
- R5: Replies are decoded correctly for any round-trip delay from zero to more than two clock periods. `rsp_delay` rises by exactly one for each added system clock of delay.
- R6: The check code is computed over the error and position bits, MSB first, with the register preset to 5'b11111 and polynomial x^5+x^2+1. `rsp_crc_error` is 1 exactly when the received check bits differ from this value.
- R7: A completed transfer produces exactly `POS_W`+16 falling edges of `enc_clk`.
- R8: If no start bit arrives within `cfg_timeout` reply-phase clock periods, the clock stops high after 8+`cfg_timeout` falling edges. The response then has `rsp_timeout`=1 and `rsp_crc_error`=0.
- R9: `req_ready` is low from the response until `cfg_recover`+1 cycles after the `rsp_valid` cycle. A request held during that interval starts no clock activity.
- R10: Every low phase of `enc_clk` lasts exactly `cfg_half` system clocks.
- R11: `rsp_valid` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Transfer request, taken while `req_ready` is high |
| req_code | input | 3 | Command code for the transfer |
| cfg_half | input | DIV_W | Line clock half-period in system clocks (at least 1) |
| cfg_timeout | input | TMO_W | Reply-phase periods allowed before the start bit |
| cfg_recover | input | REC_W | Idle-high recovery time in system clocks |
| req_ready | output | 1 | Block is idle and will accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_pos | output | POS_W | Received position value |
| rsp_err | output | 2 | Received error bits |
| rsp_crc_error | output | 1 | Check-code mismatch |
| rsp_timeout | output | 1 | No start bit arrived |
| rsp_delay | output | DLY_W | Measured start-bit delay in system clocks |
| enc_clk | output | 1 | Line clock, resting high |
| enc_dout | output | 1 | Command data to the transceiver |
| enc_dir | output | 1 | Transceiver driver enable |
| enc_din | input | 1 | Reply data from the transceiver |

## Verification
The line-side results (falling-edge count, command bits, driver-enable window and low-phase length) are observed edge by edge while the transfer runs. They are judged once `rsp_valid` appears. The response fields are read in the `rsp_valid` cycle itself. The recovery result is the count of cycles, starting with that one, in which `req_ready` stays low, and it is expected to be `cfg_recover`+1. All signals are sampled on the falling system-clock edge, a half cycle after the registers that drive them change. The delay figure is judged as a difference from the zero-delay run at the same half-period, so the fixed synchroniser latency drops out.

// File: rtl/enc_link_pkg.sv
package enc_link_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RECOV} link_st_e;

  localparam int LEAD_PULSES = 2;
  localparam int CMD_BITS    = 6;
  localparam int ERR_BITS    = 2;
  localparam int CRC_BITS    = 5;
  localparam int REPLY_FIRST = LEAD_PULSES + CMD_BITS;

  // command word: code followed by its complement
  function automatic logic [CMD_BITS-1:0] mode_word(input logic [2:0] code);
    return {code, ~code};
  endfunction

  // one serial step of the x^5 + x^2 + 1 check register
  function automatic logic [CRC_BITS-1:0] crc5_step(input logic [CRC_BITS-1:0] c,
                                                    input logic b);
    logic fb;
    fb = c[4] ^ b;
    return {c[3], c[2], c[1] ^ fb, c[0], fb};
  endfunction
endpackage

// File: rtl/enc_clk_gen.sv
module enc_clk_gen #(
  parameter int DIV_W = 12,
  parameter int IDX_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [DIV_W-1:0] half_i,
  input  logic             keep_i,
  output logic             clk_o,
  output logic             run_o,
  output logic             fall_o,
  output logic             per_end_o,
  output logic [IDX_W-1:0] per_idx_o,
  output logic [IDX_W-1:0] fall_idx_o
);
  logic             run_q, clk_q;
  logic [DIV_W-1:0] hcnt_q;
  logic [IDX_W-1:0] idx_q;
  logic             half_done_w;

  assign half_done_w = (hcnt_q == half_i - DIV_W'(1));
  assign per_end_o   = run_q && half_done_w && clk_q;
  assign fall_o      = (!run_q && start_i) || (per_end_o && keep_i);
  assign fall_idx_o  = run_q ? idx_q + IDX_W'(1) : '0;
  assign per_idx_o   = idx_q;
  assign clk_o       = clk_q;
  assign run_o       = run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      clk_q  <= 1'b1;
      hcnt_q <= '0;
      idx_q  <= '0;
    end else if (!run_q) begin
      if (start_i) begin
        run_q  <= 1'b1;
        clk_q  <= 1'b0;
        hcnt_q <= '0;
        idx_q  <= '0;
      end
    end else if (half_done_w) begin
      hcnt_q <= '0;
      if (!clk_q) begin
        clk_q <= 1'b1;
      end else if (keep_i) begin
        clk_q <= 1'b0;
        idx_q <= idx_q + IDX_W'(1);
      end else begin
        run_q <= 1'b0;
      end
    end else begin
      hcnt_q <= hcnt_q + DIV_W'(1);
    end
  end

  // R1: a stopped generator holds the line clock high
  a_r1_rest_high: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> clk_q);
endmodule

// File: rtl/enc_reply_rx.sv
module enc_reply_rx
  import enc_link_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int DIV_W = 12,
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din_i,
  input  logic             arm_i,
  input  logic             clr_i,
  input  logic [DIV_W-1:0] half_i,
  output logic             seen_o,
  output logic             done_o,
  output logic [1:0]       err_o,
  output logic [POS_W-1:0] pos_o,
  output logic             crc_bad_o,
  output logic [DLY_W-1:0] delay_o
);
  localparam int RX_BITS = ERR_BITS + POS_W + CRC_BITS;
  localparam int MSG_BITS = ERR_BITS + POS_W;
  localparam int NB_W = $clog2(RX_BITS + 1);
  localparam int ST_W = DIV_W + 2;

  logic               din_m, din_s;
  logic               armed_q, seen_q, done_q;
  logic [DLY_W-1:0]   dcnt_q, delay_q;
  logic [ST_W-1:0]    stim_q;
  logic [NB_W-1:0]    nbits_q;
  logic [RX_BITS-1:0] sh_q;
  logic [CRC_BITS-1:0] crc_q;
  logic [ST_W-1:0]    h_ext, first_wait, next_wait;
  logic               smp_w;

  assign h_ext      = ST_W'(half_i);
  assign first_wait = h_ext + (h_ext << 1) - ST_W'(1);
  assign next_wait  = (h_ext << 1) - ST_W'(1);
  assign smp_w      = seen_q && !done_q && (stim_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      din_m <= 1'b0;
      din_s <= 1'b0;
    end else begin
      din_m <= din_i;
      din_s <= din_m;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      dcnt_q  <= '0;
      delay_q <= '0;
      stim_q  <= '0;
      nbits_q <= '0;
      sh_q    <= '0;
      crc_q   <= '1;
    end else if (clr_i) begin
      armed_q <= 1'b0;
      seen_q  <= 1'b0;
    end else if (arm_i) begin
      armed_q <= 1'b1;
      seen_q  <= 1'b0;
      done_q  <= 1'b0;
      dcnt_q  <= '0;
      nbits_q <= '0;
      crc_q   <= '1;
    end else if (armed_q && !seen_q) begin
      if (din_s) begin
        seen_q  <= 1'b1;
        delay_q <= dcnt_q;
        stim_q  <= first_wait;
      end else if (dcnt_q != '1) begin
        dcnt_q <= dcnt_q + DLY_W'(1);
      end
    end else if (seen_q && !done_q) begin
      if (smp_w) begin
        sh_q   <= {sh_q[RX_BITS-2:0], din_s};
        stim_q <= next_wait;
        if (nbits_q < NB_W'(MSG_BITS)) crc_q <= crc5_step(crc_q, din_s);
        if (nbits_q == NB_W'(RX_BITS - 1)) done_q <= 1'b1;
        else nbits_q <= nbits_q + NB_W'(1);
      end else begin
        stim_q <= stim_q - ST_W'(1);
      end
    end
  end

  assign seen_o    = seen_q;
  assign done_o    = done_q;
  assign delay_o   = delay_q;
  assign err_o     = sh_q[RX_BITS-1 -: ERR_BITS];
  assign pos_o     = sh_q[CRC_BITS +: POS_W];
  assign crc_bad_o = (crc_q != sh_q[CRC_BITS-1:0]);

  // R5: the measured delay holds still once the start bit has been taken
  a_r5_delay_hold: assert property (@(posedge clk) disable iff (!rst_n)
    seen_q && $past(seen_q) && !$past(arm_i) |-> $stable(delay_q));
  // R4: sampling only happens after a start bit
  a_r4_sample_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    smp_w |-> armed_q);
endmodule

// File: rtl/enc_link_master.sv
module enc_link_master
  import enc_link_pkg::*;
#(
  parameter int POS_W = 16,
  parameter int DIV_W = 12,
  parameter int TMO_W = 8,
  parameter int REC_W = 8,
  parameter int DLY_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [2:0]       req_code,
  input  logic [DIV_W-1:0] cfg_half,
  input  logic [TMO_W-1:0] cfg_timeout,
  input  logic [REC_W-1:0] cfg_recover,
  output logic             req_ready,
  output logic             rsp_valid,
  output logic [POS_W-1:0] rsp_pos,
  output logic [1:0]       rsp_err,
  output logic             rsp_crc_error,
  output logic             rsp_timeout,
  output logic [DLY_W-1:0] rsp_delay,
  output logic             enc_clk,
  output logic             enc_dout,
  output logic             enc_dir,
  input  logic             enc_din
);
  localparam int FRAME_BITS = 1 + ERR_BITS + POS_W + CRC_BITS;
  localparam int IDX_W = $clog2(REPLY_FIRST + FRAME_BITS + (1 << TMO_W) + 2);

  link_st_e          st_q;
  logic [2:0]        code_q;
  logic [DIV_W-1:0]  half_q;
  logic [TMO_W-1:0]  tmo_q;
  logic [REC_W-1:0]  rec_q, rcnt_q;
  logic              tmo_flag_q, dout_q, dir_q;

  logic              cg_run, cg_fall, cg_pend;
  logic [IDX_W-1:0]  cg_idx, cg_fidx, nk_w;
  logic              start_w, keep_w, tmo_hit_w, arm_w, finish_w;
  logic              rx_seen, rx_done, rx_crc_bad;
  logic [1:0]        rx_err;
  logic [POS_W-1:0]  rx_pos;
  logic [DLY_W-1:0]  rx_delay;
  logic [CMD_BITS-1:0] cmd_w;
  logic [2:0]        bsel_w;

  assign start_w   = (st_q == ST_IDLE) && req_valid;
  assign nk_w      = cg_idx - IDX_W'(REPLY_FIRST - 1);
  assign tmo_hit_w = (cg_idx >= IDX_W'(REPLY_FIRST)) && !rx_seen &&
                     (nk_w >= IDX_W'(tmo_q));
  assign keep_w    = (cg_idx < IDX_W'(REPLY_FIRST)) ||
                     (!tmo_hit_w && ((nk_w < IDX_W'(FRAME_BITS)) || !rx_seen));
  assign arm_w     = cg_fall && (cg_fidx == IDX_W'(REPLY_FIRST));
  assign finish_w  = (st_q == ST_XFER) && !cg_run && (rx_done || tmo_flag_q);
  assign cmd_w     = mode_word(code_q);
  assign bsel_w    = 3'(IDX_W'(REPLY_FIRST - 1) - cg_fidx);

  enc_clk_gen #(.DIV_W(DIV_W), .IDX_W(IDX_W)) u_clk (
    .clk(clk), .rst_n(rst_n), .start_i(start_w), .half_i(half_q),
    .keep_i(keep_w), .clk_o(enc_clk), .run_o(cg_run), .fall_o(cg_fall),
    .per_end_o(cg_pend), .per_idx_o(cg_idx), .fall_idx_o(cg_fidx));

  enc_reply_rx #(.POS_W(POS_W), .DIV_W(DIV_W), .DLY_W(DLY_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .din_i(enc_din), .arm_i(arm_w),
    .clr_i(finish_w), .half_i(half_q), .seen_o(rx_seen), .done_o(rx_done),
    .err_o(rx_err), .pos_o(rx_pos), .crc_bad_o(rx_crc_bad), .delay_o(rx_delay));

  // command shifter and driver enable, both changing on falling edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout_q <= 1'b0;
      dir_q  <= 1'b0;
    end else if (cg_fall) begin
      if (cg_fidx >= IDX_W'(LEAD_PULSES) && cg_fidx < IDX_W'(REPLY_FIRST)) begin
        dout_q <= cmd_w[bsel_w];
        dir_q  <= 1'b1;
      end else begin
        dout_q <= 1'b0;
        dir_q  <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q          <= ST_IDLE;
      code_q        <= '0;
      half_q        <= DIV_W'(1);
      tmo_q         <= '0;
      rec_q         <= '0;
      rcnt_q        <= '0;
      tmo_flag_q    <= 1'b0;
      rsp_valid     <= 1'b0;
      rsp_pos       <= '0;
      rsp_err       <= '0;
      rsp_crc_error <= 1'b0;
      rsp_timeout   <= 1'b0;
      rsp_delay     <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          code_q     <= req_code;
          half_q     <= cfg_half;
          tmo_q      <= cfg_timeout;
          rec_q      <= cfg_recover;
          tmo_flag_q <= 1'b0;
          st_q       <= ST_XFER;
        end
        ST_XFER: begin
          if (cg_pend && tmo_hit_w) tmo_flag_q <= 1'b1;
          if (finish_w) begin
            rsp_valid     <= 1'b1;
            rsp_timeout   <= tmo_flag_q;
            rsp_pos       <= tmo_flag_q ? '0 : rx_pos;
            rsp_err       <= tmo_flag_q ? '0 : rx_err;
            rsp_crc_error <= !tmo_flag_q && rx_crc_bad;
            rsp_delay     <= tmo_flag_q ? '0 : rx_delay;
            rcnt_q        <= '0;
            st_q          <= ST_RECOV;
          end
        end
        ST_RECOV: begin
          if (rcnt_q == rec_q) st_q <= ST_IDLE;
          else rcnt_q <= rcnt_q + REC_W'(1);
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign enc_dout  = dout_q;
  assign enc_dir   = dir_q;

  // R1: line clock high outside a transfer
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    st_q != ST_XFER |-> enc_clk);
  // R3: driver enable confined to the six command periods
  a_r3_dir_window: assert property (@(posedge clk) disable iff (!rst_n)
    enc_dir |-> (st_q == ST_XFER) && (cg_idx >= IDX_W'(LEAD_PULSES)) &&
                (cg_idx < IDX_W'(REPLY_FIRST)));
  // R2: command data only moves on a falling line-clock edge
  a_r2_dout_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !cg_fall |=> $stable(enc_dout));
  // R11: single-cycle response strobe
  a_r11_one_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R9: no request accepted in the response cycle
  a_r9_busy_at_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !req_ready);
  // R8: a timed-out response carries no check-code error
  a_r8_timeout_clean: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_timeout |-> !rsp_crc_error);
endmodule

// File: tb/tb_enc_link_master.sv
module tb_enc_link_master;
  localparam int CLK_PERIOD = 10;
  localparam int POS_W = 12;
  localparam int DIV_W = 8;
  localparam int TMO_W = 6;
  localparam int REC_W = 5;
  localparam int DLY_W = 10;
  localparam int MSG_W = 2 + POS_W;
  localparam int NFR = POS_W + 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [2:0] req_code = '0;
  logic [DIV_W-1:0] cfg_half = DIV_W'(2);
  logic [TMO_W-1:0] cfg_timeout = '0;
  logic [REC_W-1:0] cfg_recover = '0;
  logic req_ready, rsp_valid, rsp_crc_error, rsp_timeout;
  logic [POS_W-1:0] rsp_pos;
  logic [1:0] rsp_err;
  logic [DLY_W-1:0] rsp_delay;
  logic enc_clk, enc_dout, enc_dir;
  logic enc_din = 1'b0;

  int errors = 0;
  int checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  enc_link_master #(.POS_W(POS_W), .DIV_W(DIV_W), .TMO_W(TMO_W),
                    .REC_W(REC_W), .DLY_W(DLY_W)) dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_code(req_code),
    .cfg_half(cfg_half), .cfg_timeout(cfg_timeout), .cfg_recover(cfg_recover),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_pos(rsp_pos),
    .rsp_err(rsp_err), .rsp_crc_error(rsp_crc_error), .rsp_timeout(rsp_timeout),
    .rsp_delay(rsp_delay), .enc_clk(enc_clk), .enc_dout(enc_dout),
    .enc_dir(enc_dir), .enc_din(enc_din));

  // encoder model settings, written only by the stimulus process
  int txn_id = 0;
  int dly = 0;
  int exp_h = 2;
  bit silent = 1'b0;
  bit busy = 1'b0;
  logic [NFR-1:0] frame = '0;

  // check value restated as an integer long-division loop
  function automatic logic [4:0] ref_crc(input logic [MSG_W-1:0] msg);
    int c = 31;
    for (int i = MSG_W - 1; i >= 0; i--) begin
      int t = ((c >> 4) & 1) ^ int'(msg[i]);
      c = (c << 1) & 31;
      if (t != 0) c = c ^ 5;
    end
    return 5'(c);
  endfunction

  // cable model: delayed line clock, encoder answers on its falling edges
  logic [31:0] dline = '1;
  logic prevd = 1'b1;
  int enc_id = 0;
  int efall = 0;
  always @(posedge clk) begin
    dline <= {dline[30:0], enc_clk};
    if (txn_id != enc_id) begin
      enc_id  <= txn_id;
      efall   <= 0;
      enc_din <= 1'b0;
      prevd   <= 1'b1;
    end else begin
      prevd <= dline[dly];
      if (prevd && !dline[dly]) begin
        if (efall >= 8 && efall - 8 < NFR && !silent) enc_din <= frame[NFR-1-(efall-8)];
        else enc_din <= 1'b0;
        efall <= efall + 1;
      end
    end
  end

  // line monitor, sampled away from the active edge
  int mon_id = 0;
  int falls = 0, dir_rises = 0, lowlen = 0, low_bad = 0, dir_bad = 0, idle_bad = 0;
  logic [5:0] cmd_sh = '0;
  logic mprev = 1'b1;
  always @(negedge clk) begin
    if (mon_id != txn_id) begin
      mon_id = txn_id; falls = 0; dir_rises = 0; lowlen = 0;
      low_bad = 0; dir_bad = 0; cmd_sh = '0;
    end
    if (mprev && !enc_clk) falls++;
    if (!mprev && enc_clk) begin
      if (lowlen != exp_h) low_bad++;
      lowlen = 0;
      if (enc_dir) begin dir_rises++; cmd_sh = {cmd_sh[4:0], enc_dout}; end
    end
    if (!enc_clk) lowlen++;
    if (enc_dir && (falls < 3 || falls > 8)) dir_bad++;
    if (!busy && !enc_clk) idle_bad++;
    mprev = enc_clk;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_txn(input int code, input int h, input int tmo, input int rec,
                        input int d, input int p, input int e, input bit bad,
                        input bit sil, output int dseen);
    logic [MSG_W-1:0] msg;
    logic [4:0] cc;
    int n, f_at_rsp, nready;
    bit got;
    dseen = 0;
    n = 0;
    while (!req_ready && n < 3000) begin @(negedge clk); n++; end
    msg = {2'(e), POS_W'(p)};
    cc = ref_crc(msg) ^ (bad ? 5'b00100 : 5'b00000);
    frame = {1'b1, msg, cc};
    dly = d; silent = sil; exp_h = h;
    cfg_half = DIV_W'(h); cfg_timeout = TMO_W'(tmo); cfg_recover = REC_W'(rec);
    req_code = 3'(code);
    busy = 1'b1;
    txn_id++;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 20000 && !got; k++) begin
      if (rsp_valid) got = 1'b1;
      else @(negedge clk);
    end
    chk(got, "R11 response strobe seen", got, 1);
    busy = 1'b0;
    if (!got) return;
    if (sil) begin
      chk(rsp_timeout == 1'b1, "R8 timeout flag", rsp_timeout, 1);
      chk(rsp_crc_error == 1'b0, "R8 no crc flag on timeout", rsp_crc_error, 0);
      chk(falls == 8 + tmo, "R8 falling edges before stop", falls, 8 + tmo);
    end else begin
      chk(rsp_timeout == 1'b0, "R4 no timeout", rsp_timeout, 0);
      chk(rsp_pos == POS_W'(p), "R4/R5 position", rsp_pos, p);
      chk(rsp_err == 2'(e), "R4 error bits", rsp_err, e);
      chk(rsp_crc_error == bad, "R6 crc flag", rsp_crc_error, bad);
      chk(falls == POS_W + 16, "R7 falling edges per transfer", falls, POS_W + 16);
      dseen = int'(rsp_delay);
    end
    chk(cmd_sh == {3'(code), ~3'(code)}, "R2 command bits", cmd_sh, {3'(code), ~3'(code)});
    chk(dir_rises == 6, "R3 driver enable periods", dir_rises, 6);
    chk(dir_bad == 0, "R3 driver enable window", dir_bad, 0);
    chk(low_bad == 0, "R10 low phase length", low_bad, 0);
    f_at_rsp = falls;
    nready = 0;
    while (!req_ready && nready < 200) begin
      req_valid = 1'b1;
      nready++;
      @(negedge clk);
    end
    req_valid = 1'b0;
    chk(nready == rec + 1, "R9 recovery length", nready, rec + 1);
    chk(falls == f_at_rsp && enc_clk, "R9 request ignored in recovery", falls, f_at_rsp);
    chk(idle_bad == 0, "R1 clock high outside transfers", idle_bad, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin
    int ds, base;
    repeat (3) @(negedge clk);
    chk(enc_clk == 1'b1, "R1 clock high after reset", enc_clk, 1);
    chk(enc_dir == 1'b0, "R3 driver off after reset", enc_dir, 0);
    chk(req_ready == 1'b1, "R9 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R11 no strobe after reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    // every command code
    for (int c = 0; c < 8; c++)
      do_txn(c, 2, 40, c, 0, (c * 397 + 5) % 4096, c % 4, 1'b0, 1'b0, ds);
    // delay sweep at half-period 2 (line period 4), up to three periods
    base = 0;
    for (int d = 0; d <= 12; d++) begin
      do_txn(5, 2, 40, 1, d, (d * 53 + 22) % 4096, 2, 1'b0, 1'b0, ds);
      if (d == 0) base = ds;
      else chk(ds == base + d, "R5 delay reading", ds, base + d);
    end
    // delay sweep at half-period 3
    for (int d = 0; d <= 14; d += 2) begin
      do_txn(2, 3, 40, 0, d, (d * 211 + 33) % 4096, 1, 1'b0, 1'b0, ds);
      if (d == 0) base = ds;
      else chk(ds == base + d, "R5 delay reading", ds, base + d);
    end
    // slower clock, all error-bit patterns, extreme positions
    for (int e = 0; e < 4; e++)
      do_txn(e, 5, 40, 2, 7, (e == 0) ? 0 : (e == 3) ? 4095 : e * 1111, e, 1'b0, 1'b0, ds);
    // corrupted check bits
    do_txn(6, 2, 40, 0, 3, 2730, 0, 1'b1, 1'b0, ds);
    do_txn(1, 4, 40, 3, 9, 1365, 3, 1'b1, 1'b0, ds);
    // silent encoder: short and long timeouts
    do_txn(4, 2, 3, 2, 0, 0, 0, 1'b0, 1'b1, ds);
    do_txn(7, 3, 25, 0, 0, 0, 0, 1'b0, 1'b1, ds);
    // normal transfer after a timeout
    do_txn(3, 2, 40, 0, 4, 3000, 1, 1'b0, 1'b0, ds);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule